// File: doc/BRIEF.md
# Single-Slope ADC Conversion Controller

This block sequences the digital side of a single-slope analog-to-digital converter. Between conversions it holds the ramp capacitor discharged. When the PWM half-cycle indicator enters the selected half of the switching period, it releases the capacitor and starts a shared ramp counter. Every analog channel has its own comparator, which trips as the common ramp voltage passes that channel's input. The controller times all channels in parallel against that one ramp.

When a channel's comparator first rises, the channel latches the current counter value. A channel that never trips before the counter tops out reads full scale. The conversion ends when every channel has a result or the counter saturates. At that point a done flag is raised and the capacitor goes back into reset. The counter can step at the full clock rate or at half of it. A conversion is only allowed after the capacitor has been held in reset for a minimum number of cycles.

Top module: `ramp_conv_ctrl`

## Requirements
- R1: After reset, cap_rst is 1, done is 0 and every channel value is 0.
- R2: A start event is the half indicator pwm_half entering the half named by half_sel (half_sel=0: pwm_half goes 1 to 0; half_sel=1: pwm_half goes 0 to 1). When a start is accepted, cap_rst falls at the next clock edge. In that same edge done clears and all channel values become 0.
- R3: A start event is accepted only when cap_rst has been held high for MIN_HOLD cycles (default 8). An event seen earlier is ignored: cap_rst stays 1, done and the channel values keep their state, and no conversion takes place.
- R4: With fast_rate=1 the counter reads k in ramp cycle k, where cycle 0 is the first cycle with cap_rst low. With fast_rate=0 it reads floor(k/2).
- R5: Channel i stores the counter value of the first ramp cycle in which cmp[i] is sampled 1 after having been 0 in the cycle before. Later edges on cmp[i] in the same conversion are ignored.
- R6: A comparator that is already high when the ramp starts and never falls produces no rising edge. Its channel therefore reads full scale.
- R7: When the counter reaches 2^CW-1 (ramp cycle 2^CW-1 at fast rate, 2*(2^CW-1) at half rate), every channel without a result reads 2^CW-1 and the conversion ends.
- R8: done rises, and cap_rst returns to 1, at the edge that closes the ramp cycle in which the last channel trips or the counter saturates. done stays 1 until the next accepted start.
- R9: Start events that arrive while a ramp is running are ignored, so a running conversion is neither restarted nor shortened.
- R10: The value of channel i appears on ch_vals[i*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_half | input | 1 | PWM half-cycle indicator (0 first half, 1 second half) |
| half_sel | input | 1 | Half of the PWM cycle in which conversion starts |
| fast_rate | input | 1 | 1: counter steps every clock; 0: every second clock |
| cmp | input | NCH | Comparator outputs, one per channel |
| cap_rst | output | 1 | Ramp capacitor discharge control, active high |
| done | output | 1 | Conversion complete |
| ch_vals | output | NCH*CW | Captured counts, channel i at bits i*CW +: CW |

## Verification
A stuck phase register shows at the ports as one of two faults. Either cap_rst never falls within MIN_HOLD plus two cycles of a valid start event, or done fails to rise by ramp cycle 2*(2^CW-1). A counter that steps at the wrong rate, or does not restart, offsets every captured count. That error is visible as soon as done rises. A capture flag that leaks across conversions shows on the next conversion: a channel reads 0 or an old value instead of its trip time. A hold gate that opens too early lets a back-to-back event clear the results within two cycles.

// File: rtl/sscv_pkg.sv
`timescale 1ns/1ps
package sscv_pkg;

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RAMP = 1'b1
    } phase_e;

    typedef struct packed {
        logic start;
        logic run;
        logic finish;
    } seq_ctl_t;

endpackage

// File: rtl/sscv_trigger.sv
`timescale 1ns/1ps
module sscv_trigger #(
    parameter int MIN_HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_half,
    input  logic half_sel,
    input  logic hold_active,
    input  logic busy,
    output logic start
);
    localparam int HW = $clog2(MIN_HOLD + 1);
    localparam logic [HW-1:0] HOLD_DONE = HW'(MIN_HOLD);

    logic          prev_q;
    logic [HW-1:0] hold_q;
    logic          entered;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            hold_q <= '0;
        end else begin
            prev_q <= pwm_half;
            if (!hold_active)
                hold_q <= '0;
            else if (hold_q != HOLD_DONE)
                hold_q <= hold_q + 1'b1;
        end
    end

    assign entered = (pwm_half == half_sel) && (prev_q != half_sel);
    assign start   = entered && !busy && (hold_q == HOLD_DONE);

    // R3
    hold_ok_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (hold_active && $past(hold_active)));

endmodule

// File: rtl/sscv_ramp.sv
`timescale 1ns/1ps
module sscv_ramp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          fast,
    output logic [CW-1:0] count,
    output logic          sat
);
    localparam logic [CW-1:0] TOP = '1;

    logic          ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (run) begin
            ph_q <= ~ph_q;
            if ((fast || ph_q) && (cnt_q != TOP))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign sat   = (cnt_q == TOP);

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clear) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/sscv_chan.sv
`timescale 1ns/1ps
module sscv_chan
    import sscv_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ctl_t      ctl,
    input  logic          cmp,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] val,
    output logic          hit
);
    localparam logic [CW-1:0] FULL = '1;

    logic          cmp_q;
    logic          tripped_q;
    logic [CW-1:0] val_q;
    logic          rise;

    assign rise = cmp && !cmp_q;

    always_ff @(posedge clk) begin
        if (rst) cmp_q <= 1'b0;
        else     cmp_q <= cmp;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.start) begin
            val_q     <= '0;
            tripped_q <= 1'b0;
        end else if (ctl.run && !tripped_q) begin
            if (rise) begin
                val_q     <= count;
                tripped_q <= 1'b1;
            end else if (ctl.finish) begin
                val_q <= FULL;
            end
        end
    end

    assign val = val_q;
    assign hit = tripped_q || (ctl.run && rise);

    // R5
    keep_first_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_q && !ctl.start) |=> $stable(val_q));

endmodule

// File: rtl/ramp_conv_ctrl.sv
`timescale 1ns/1ps
module ramp_conv_ctrl
    import sscv_pkg::*;
#(
    parameter int NCH      = 5,
    parameter int CW       = 8,
    parameter int MIN_HOLD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_half,
    input  logic              half_sel,
    input  logic              fast_rate,
    input  logic [NCH-1:0]    cmp,
    output logic              cap_rst,
    output logic              done,
    output logic [NCH*CW-1:0] ch_vals
);
    phase_e        phase_q;
    logic          done_q;
    logic          start;
    logic          sat;
    logic [CW-1:0] count;
    logic [NCH-1:0] hits;
    seq_ctl_t      ctl;

    assign ctl.start  = start;
    assign ctl.run    = (phase_q == PH_RAMP);
    assign ctl.finish = ctl.run && (sat || (&hits));

    sscv_trigger #(.MIN_HOLD(MIN_HOLD)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .pwm_half   (pwm_half),
        .half_sel   (half_sel),
        .hold_active(phase_q == PH_HOLD),
        .busy       (ctl.run),
        .start      (start)
    );

    sscv_ramp #(.CW(CW)) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .clear(start),
        .run  (ctl.run),
        .fast (fast_rate),
        .count(count),
        .sat  (sat)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sscv_chan #(.CW(CW)) u_ch (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .cmp  (cmp[i]),
            .count(count),
            .val  (ch_vals[i*CW +: CW]),
            .hit  (hits[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            done_q  <= 1'b0;
        end else if (start) begin
            phase_q <= PH_RAMP;
            done_q  <= 1'b0;
        end else if (ctl.finish) begin
            phase_q <= PH_HOLD;
            done_q  <= 1'b1;
        end
    end

    assign cap_rst = (phase_q == PH_HOLD);
    assign done    = done_q;

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $rose(cap_rst));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> cap_rst);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_rst) |-> !done);

    // R7
    sat_end_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && sat) |=> cap_rst);

endmodule

// File: tb/ramp_conv_ctrl_test.sv
`timescale 1ns/1ps
module ramp_conv_ctrl_test;
    localparam int NCH      = 5;
    localparam int CW       = 8;
    localparam int MIN_HOLD = 8;
    localparam int MAXV     = (1 << CW) - 1;
    localparam int NEVER    = 100000;
    localparam int NV       = 6;

    localparam int VSEL [NV]  = '{0, 1, 0, 1, 1, 0};
    localparam int VFAST[NV]  = '{1, 1, 0, 1, 0, 1};
    localparam int VTRIP[NV][NCH] = '{
        '{3, 10, 20, 7, 15},
        '{0, 1, 2, 3, 4},
        '{5, 6, 9, 12, 40},
        '{30, NEVER, 2, 100, 50},
        '{NEVER, NEVER, NEVER, NEVER, NEVER},
        '{8, 8, 8, 8, 8}
    };

    logic clk = 1'b0;
    logic rst;
    logic pwm_half, half_sel, fast_rate;
    logic [NCH-1:0] cmp;
    logic cap_rst, done;
    logic [NCH*CW-1:0] ch_vals;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    ramp_conv_ctrl #(.NCH(NCH), .CW(CW), .MIN_HOLD(MIN_HOLD)) uut (
        .clk(clk), .rst(rst), .pwm_half(pwm_half), .half_sel(half_sel),
        .fast_rate(fast_rate), .cmp(cmp), .cap_rst(cap_rst), .done(done),
        .ch_vals(ch_vals)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int chv(input int i);
        return int'(ch_vals[i*CW +: CW]);
    endfunction

    task automatic run_conv(input int sel, input int fast, input int t[NCH],
                            input logic [NCH-1:0] pre, input bit retrig);
        int sat_k, all_k, end_k, seen, expv;
        @(negedge clk);
        half_sel  = sel[0];
        fast_rate = fast[0];
        cmp       = pre;
        pwm_half  = ~sel[0];
        repeat (MIN_HOLD + 3) @(negedge clk);
        pwm_half = sel[0];
        @(negedge clk);
        // R2: ramp cycle 0
        chk(cap_rst == 1'b0, "R2", "cap_rst at ramp start", cap_rst, 0);
        chk(done == 1'b0, "R2", "done at ramp start", done, 0);
        chk(ch_vals == '0, "R2", "values cleared at start", ch_vals, 0);

        sat_k = fast ? MAXV : 2 * MAXV;
        all_k = 0;
        for (int i = 0; i < NCH; i++) begin
            if (pre[i] || t[i] >= NEVER) all_k = NEVER;
            else if (t[i] > all_k && all_k != NEVER) all_k = t[i];
        end
        end_k = (all_k < sat_k) ? all_k : sat_k;
        seen = -1;
        for (int k = 0; k <= end_k + 2; k++) begin
            for (int i = 0; i < NCH; i++)
                if (!pre[i] && t[i] == k) cmp[i] = 1'b1;
            if (!pre[0] && t[0] + 2 == k) cmp[0] = 1'b0;
            if (!pre[0] && t[0] + 4 == k) cmp[0] = 1'b1;
            if (retrig && k == 2) pwm_half = ~sel[0];
            if (retrig && k == 4) pwm_half = sel[0];
            @(negedge clk);
            if (done) begin
                seen = k;
                break;
            end
        end
        // R8 / R7 / R9: end of conversion timing
        chk(seen == end_k, "R8", "ramp cycle of done", seen, end_k);
        chk(cap_rst == 1'b1, "R8", "cap_rst after done", cap_rst, 1);
        for (int i = 0; i < NCH; i++) begin
            if (!pre[i] && t[i] <= end_k) expv = fast ? t[i] : t[i] / 2;
            else expv = MAXV;
            // R5 R4 R10 capture, R6 R7 full scale
            chk(chv(i) == expv, (expv == MAXV) ? "R7" : "R5",
                $sformatf("channel %0d value", i), chv(i), expv);
        end
        cmp = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pwm_half = 1'b0; half_sel = 1'b0; fast_rate = 1'b1; cmp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(cap_rst == 1'b1, "R1", "cap_rst after reset", cap_rst, 1);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(ch_vals == '0, "R1", "values after reset", ch_vals, 0);

        // table of vectors: R2 R4 R5 R7 R8 R10
        for (int v = 0; v < NV; v++)
            run_conv(VSEL[v], VFAST[v], VTRIP[v], '0, 1'b0);

        // R6: channel 2 already high at start, never rises
        run_conv(1, 1, '{5, 5, NEVER, 5, 5}, 5'b00100, 1'b0);

        // R9: start events inside the ramp are ignored
        run_conv(0, 1, '{10, 12, 14, 16, 18}, '0, 1'b1);

        // R3: event too soon after done is ignored
        @(negedge clk);
        pwm_half = 1'b1;
        @(negedge clk);
        pwm_half = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(cap_rst == 1'b1, "R3", "cap_rst after early event", cap_rst, 1);
            chk(done == 1'b1, "R3", "done after early event", done, 1);
            chk(chv(4) == 18, "R3", "channel 4 kept", chv(4), 18);
        end

        // R3: after the hold, the next event is accepted again
        run_conv(1, 0, '{4, 4, 4, 4, 4}, '0, 1'b0);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule